// File: doc/BRIEF.md
# Configurable External Interrupt Controller

The block monitors eight external interrupt lines and turns a programmable condition on each of them into an interrupt request for a processor. Each line has its own two-bit trigger selector: low level, any change, falling edge or rising edge. The selectors sit in two 8-bit configuration words. One word covers lines 0 to 3 and the other covers lines 4 to 7. An enable mask picks which lines may record and raise events. A global enable input gates every request towards the processor.

Edge-type triggers are captured in a sticky event flag. Software clears a flag by writing a 1 to its bit. The processor clears a flag by acknowledging that line's index. A low-level trigger bypasses the flags and requests for as long as the line stays low. Each line can be turned around and driven by the chip's own port logic, and the trigger logic always watches the value that actually drives the line. This lets software raise an interrupt by writing the line. A fixed-priority encoder reports the lowest-numbered pending line as a valid strobe and a 3-bit index.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset all event flags read 0, `req_valid` is 0, every trigger selector is 00 and the enable mask is 0.
- R2: The selector of line i (i = 0..3) is bits [2i+1:2i] of the word written with `sense_sel` = 0. The selector of line i (i = 4..7) is bits [2(i-4)+1:2(i-4)] of the word written with `sense_sel` = 1. The codes are 00 low level, 01 any change, 10 falling edge, 11 rising edge.
- R3: An enabled line set to falling edge (10) or rising edge (11) sets its flag only on a transition in that direction. The line is sampled by two synchronizer stages. A transition applied before clock edge k is visible in `flags` after edge k+2 and not after edge k+1.
- R4: A line set to any change (01) sets its flag on both a rising and a falling transition.
- R5: A line whose enable mask bit is 0 never sets its flag and never requests.
- R6: A line set to low level (00) drives a request while its synchronized value is 0 and drops the request once it is 1. The request appears after edge k+1 for a change applied before edge k. Its flag is never set.
- R7: With `glob_en` at 0, `req_valid` is 0 but flags still record events. Raising `glob_en` makes a pending request visible in the same cycle.
- R8: Writing `flag_clr_we` clears every flag whose bit is 1 in `flag_clr_wdata`. Flags whose bit is 0 are left unchanged.
- R9: A pulse on `ack_valid` clears only the flag numbered by `ack_idx`.
- R10: When several lines are pending, `req_idx` is the lowest pending line number.
- R11: For a line with `pin_oe` = 1, the trigger logic watches `pin_out` and ignores `pin_in`. With `pin_oe` = 0 it watches `pin_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 8 | Sampled external line values |
| pin_oe | input | 8 | Per-line output enable from the port logic |
| pin_out | input | 8 | Per-line output value from the port logic |
| sense_we | input | 1 | Write strobe for a trigger selector word |
| sense_sel | input | 1 | Word select: 0 = lines 0-3, 1 = lines 4-7 |
| sense_wdata | input | 8 | Selector word, 2 bits per line |
| mask_we | input | 1 | Write strobe for the enable mask |
| mask_wdata | input | 8 | New enable mask |
| flag_clr_we | input | 1 | Write-one-to-clear strobe for flags |
| flag_clr_wdata | input | 8 | Flags to clear |
| glob_en | input | 1 | Global interrupt enable |
| ack_valid | input | 1 | Processor acknowledge strobe |
| ack_idx | input | 3 | Line number being acknowledged |
| flags | output | 8 | Event flags |
| req_valid | output | 1 | Some line is requesting |
| req_idx | output | 3 | Highest-priority requesting line |

## Verification
Each trigger selector is driven with falling, rising and return transitions. Comparing the flags separates the right edge from the wrong one, and any-change mode shows up as two captures. A level line is held low over several cycles and then released, which shows continuous requesting and no latching. Masking, the global enable and loopback driving with toggling `pin_in` show which source the detector watches and which gate stops a request. Overlapping flags with write-one-to-clear and indexed acknowledges show that clearing is selective and that priority falls to the lowest line.

// File: rtl/eic_pkg.sv
package eic_pkg;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_ANY  = 2'b01,
        TRIG_FALL = 2'b10,
        TRIG_RISE = 2'b11
    } trig_e;

endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
    parameter int N_PIN  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_PIN-1:0] raw,
    output logic [N_PIN-1:0] cur,
    output logic [N_PIN-1:0] prev
);
    typedef struct packed {
        logic [STAGES-1:0][N_PIN-1:0] chain;
        logic [N_PIN-1:0]             last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = raw;
        for (int s = 1; s < STAGES; s++) begin
            s_d.chain[s] = s_q.chain[s-1];
        end
        s_d.last = s_q.chain[STAGES-1];
    end

    // lines idle high, so reset to ones to avoid a false edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign cur  = s_q.chain[STAGES-1];
    assign prev = s_q.last;
endmodule

// File: rtl/eic_detect.sv
module eic_detect
    import eic_pkg::*;
#(
    parameter int N_PIN = 8
) (
    input  logic [N_PIN-1:0]      cur,
    input  logic [N_PIN-1:0]      prev,
    input  logic [N_PIN-1:0][1:0] trig,
    output logic [N_PIN-1:0]      edge_evt,
    output logic [N_PIN-1:0]      level_act,
    output logic [N_PIN-1:0]      is_level
);
    for (genvar i = 0; i < N_PIN; i++) begin : g_pin
        logic rise_w, fall_w;
        assign rise_w = cur[i] & ~prev[i];
        assign fall_w = ~cur[i] & prev[i];

        always_comb begin
            edge_evt[i]  = 1'b0;
            level_act[i] = 1'b0;
            is_level[i]  = 1'b0;
            case (trig_e'(trig[i]))
                TRIG_LOW: begin
                    is_level[i]  = 1'b1;
                    level_act[i] = ~cur[i];
                end
                TRIG_ANY:  edge_evt[i] = rise_w | fall_w;
                TRIG_FALL: edge_evt[i] = fall_w;
                TRIG_RISE: edge_evt[i] = rise_w;
                default:   edge_evt[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/eic_prio.sv
module eic_prio #(
    parameter int N_PIN = 8,
    parameter int IDX_W = $clog2(N_PIN)
) (
    input  logic [N_PIN-1:0] pend,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        valid = |pend;
        idx   = '0;
        for (int i = N_PIN - 1; i >= 0; i--) begin
            if (pend[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
    parameter int N_PIN       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int GRP         = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_PIN-1:0]             pin_in,
    input  logic [N_PIN-1:0]             pin_oe,
    input  logic [N_PIN-1:0]             pin_out,
    input  logic                         sense_we,
    input  logic [$clog2(N_PIN/GRP)-1:0] sense_sel,
    input  logic [2*GRP-1:0]             sense_wdata,
    input  logic                         mask_we,
    input  logic [N_PIN-1:0]             mask_wdata,
    input  logic                         flag_clr_we,
    input  logic [N_PIN-1:0]             flag_clr_wdata,
    input  logic                         glob_en,
    input  logic                         ack_valid,
    input  logic [$clog2(N_PIN)-1:0]     ack_idx,
    output logic [N_PIN-1:0]             flags,
    output logic                         req_valid,
    output logic [$clog2(N_PIN)-1:0]     req_idx
);
    localparam int IDX_W = $clog2(N_PIN);
    localparam int N_GRP = N_PIN / GRP;
    localparam int SEL_W = $clog2(N_GRP);

    typedef struct packed {
        logic [N_PIN-1:0][1:0] trig;
        logic [N_PIN-1:0]      mask;
        logic [N_PIN-1:0]      flag;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [N_PIN-1:0] line_eff;
    logic [N_PIN-1:0] line_cur, line_prev;
    logic [N_PIN-1:0] edge_evt, level_act, is_level;
    logic [N_PIN-1:0] flag_set, flag_clr, pending, mask_cur;

    // loopback: a driven line is watched through its own output value
    assign line_eff = (pin_oe & pin_out) | (~pin_oe & pin_in);

    eic_sync #(.N_PIN(N_PIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (line_eff),
        .cur  (line_cur),
        .prev (line_prev)
    );

    eic_detect #(.N_PIN(N_PIN)) u_detect (
        .cur      (line_cur),
        .prev     (line_prev),
        .trig     (st_q.trig),
        .edge_evt (edge_evt),
        .level_act(level_act),
        .is_level (is_level)
    );

    assign flag_set = edge_evt & st_q.mask;

    always_comb begin
        flag_clr = '0;
        if (flag_clr_we) flag_clr = flag_clr | flag_clr_wdata;
        if (ack_valid)   flag_clr = flag_clr | (N_PIN'(1) << ack_idx);
    end

    always_comb begin
        st_d = st_q;
        if (sense_we) begin
            for (int g = 0; g < N_GRP; g++) begin
                if (sense_sel == SEL_W'(g)) st_d.trig[g*GRP +: GRP] = sense_wdata;
            end
        end
        if (mask_we) st_d.mask = mask_wdata;
        // a fresh event wins over a clear in the same cycle
        st_d.flag = (st_q.flag & ~flag_clr) | flag_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pending = glob_en ? (st_q.mask & ((st_q.flag & ~is_level) | level_act))
                             : '0;

    eic_prio #(.N_PIN(N_PIN), .IDX_W(IDX_W)) u_prio (
        .pend (pending),
        .valid(req_valid),
        .idx  (req_idx)
    );

    assign flags    = st_q.flag;
    assign mask_cur = st_q.mask;
endmodule

// File: rtl/eic_chk.sv
module eic_chk #(
    parameter int N_PIN = 8,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             glob_en,
    input logic             req_valid,
    input logic [IDX_W-1:0] req_idx,
    input logic [N_PIN-1:0] pending,
    input logic [N_PIN-1:0] mask_cur,
    input logic [N_PIN-1:0] flags,
    input logic [N_PIN-1:0] flag_set,
    input logic [N_PIN-1:0] is_level,
    input logic             flag_clr_we,
    input logic [N_PIN-1:0] flag_clr_wdata
);
    logic [N_PIN-1:0] below;
    assign below = (N_PIN'(1) << req_idx) - N_PIN'(1);

    // R7
    glob_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> glob_en);

    // R5
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> mask_cur[req_idx]);

    // R10
    lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (pending[req_idx] && (pending & below) == '0));

    // R8
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_we && flag_set == '0) |=> (flags & $past(flag_clr_wdata)) == '0);

    // R6
    level_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (flags & ~$past(flags) & $past(is_level)) == '0);
endmodule

bind ext_irq_ctrl eic_chk #(.N_PIN(N_PIN), .IDX_W(IDX_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .glob_en       (glob_en),
    .req_valid     (req_valid),
    .req_idx       (req_idx),
    .pending       (pending),
    .mask_cur      (mask_cur),
    .flags         (flags),
    .flag_set      (flag_set),
    .is_level      (is_level),
    .flag_clr_we   (flag_clr_we),
    .flag_clr_wdata(flag_clr_wdata)
);

// File: tb/test_ext_irq_ctrl.sv
module test_ext_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_in = 8'hFF, pin_oe = 8'h00, pin_out = 8'h00;
    logic       sense_we = 0, sense_sel = 0;
    logic [7:0] sense_wdata = 0;
    logic       mask_we = 0, flag_clr_we = 0, glob_en = 0, ack_valid = 0;
    logic [7:0] mask_wdata = 0, flag_clr_wdata = 0;
    logic [2:0] ack_idx = 0;
    logic [7:0] flags;
    logic       req_valid;
    logic [2:0] req_idx;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] f;
        logic       v;
        logic [2:0] i;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    ext_irq_ctrl i_ext_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_oe(pin_oe),
        .pin_out(pin_out), .sense_we(sense_we), .sense_sel(sense_sel),
        .sense_wdata(sense_wdata), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .flag_clr_we(flag_clr_we), .flag_clr_wdata(flag_clr_wdata),
        .glob_en(glob_en), .ack_valid(ack_valid), .ack_idx(ack_idx),
        .flags(flags), .req_valid(req_valid), .req_idx(req_idx)
    );

    // monitor: compares at the falling edge, away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_chk++;
            if (flags !== e.f || req_valid !== e.v || (e.v && req_idx !== e.i)) begin
                n_bad++;
                $display("FAIL %s: flags=%h valid=%b idx=%0d expected flags=%h valid=%b idx=%0d",
                         e.tag, flags, req_valid, req_idx, e.f, e.v, e.i);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic expect_out(logic [7:0] f, logic v, logic [2:0] i, string tag);
        exp_q.push_back('{f, v, i, tag});
        wait (exp_q.size() == 0);
    endtask

    task automatic wr_sense(logic sel, logic [7:0] d);
        sense_we = 1; sense_sel = sel; sense_wdata = d;
        tick(1);
        sense_we = 0;
    endtask

    task automatic wr_mask(logic [7:0] d);
        mask_we = 1; mask_wdata = d;
        tick(1);
        mask_we = 0;
    endtask

    task automatic w1c(logic [7:0] d);
        flag_clr_we = 1; flag_clr_wdata = d;
        tick(1);
        flag_clr_we = 0;
    endtask

    task automatic ack(logic [2:0] i);
        ack_valid = 1; ack_idx = i;
        tick(1);
        ack_valid = 0;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1;
        tick(1);
        expect_out(8'h00, 1'b0, 3'd0, "R1 reset state");

        // R2: lines 0..3 = fall, rise, any, low ; lines 4..7 = rise, fall, any, low
        wr_sense(1'b0, 8'b00_01_11_10);
        wr_sense(1'b1, 8'b00_01_10_11);
        wr_mask(8'hFF);
        glob_en = 1;
        tick(3);
        expect_out(8'h00, 1'b0, 3'd0, "R2 idle after config");

        // R3 falling on line 0, falling on rise-mode line 1, with latency
        pin_in[0] = 0; pin_in[1] = 0;
        tick(2);
        expect_out(8'h00, 1'b0, 3'd0, "R3 not yet after two edges");
        tick(1);
        expect_out(8'h01, 1'b1, 3'd0, "R3 falling edge captured, rise-mode ignores fall");
        pin_in[1] = 1;
        tick(3);
        expect_out(8'h03, 1'b1, 3'd0, "R10 lowest of two pending, R3 rising captured");

        w1c(8'h01);
        expect_out(8'h02, 1'b1, 3'd1, "R8 write-one clears only selected flag");
        ack(3'd1);
        expect_out(8'h00, 1'b0, 3'd0, "R9 ack clears flag 1");

        // R4 any-change mode on line 2
        pin_in[2] = 0;
        tick(3);
        expect_out(8'h04, 1'b1, 3'd2, "R4 any-change falling");
        w1c(8'h04);
        pin_in[2] = 1;
        tick(3);
        expect_out(8'h04, 1'b1, 3'd2, "R4 any-change rising");
        pin_in[5] = 0;
        tick(3);
        expect_out(8'h24, 1'b1, 3'd2, "R10 line 2 ahead of line 5");
        ack(3'd2);
        expect_out(8'h20, 1'b1, 3'd5, "R9 ack clears only indexed flag");

        // R5 masked line
        wr_mask(8'hEF);
        pin_in[4] = 0;
        tick(3);
        pin_in[4] = 1;
        tick(3);
        expect_out(8'h20, 1'b1, 3'd5, "R5 masked line records nothing");
        w1c(8'hFF);
        expect_out(8'h00, 1'b0, 3'd0, "R8 clear all");

        // R7 global enable
        glob_en = 0;
        pin_in[6] = 0;
        tick(3);
        expect_out(8'h40, 1'b0, 3'd0, "R7 flag set but no request while disabled");
        glob_en = 1;
        expect_out(8'h40, 1'b1, 3'd6, "R7 request appears on enable");
        w1c(8'h40);

        // R6 low level on line 3
        pin_in[3] = 0;
        tick(2);
        expect_out(8'h00, 1'b1, 3'd3, "R6 level request without flag");
        tick(4);
        expect_out(8'h00, 1'b1, 3'd3, "R6 level request held");
        pin_in[3] = 1;
        tick(2);
        expect_out(8'h00, 1'b0, 3'd0, "R6 level request drops");

        // R11 loopback on line 5 (falling mode), pin_in[5] currently 0
        pin_out[5] = 0; pin_oe[5] = 1;
        tick(3);
        expect_out(8'h00, 1'b0, 3'd0, "R11 turnaround without change");
        pin_out[5] = 1;
        tick(3);
        expect_out(8'h00, 1'b0, 3'd0, "R11 driven rise ignored in fall mode");
        pin_in[5] = 1;
        tick(3);
        pin_in[5] = 0;
        tick(3);
        expect_out(8'h00, 1'b0, 3'd0, "R11 pin_in ignored while driven");
        pin_out[5] = 0;
        tick(3);
        expect_out(8'h20, 1'b1, 3'd5, "R11 software-driven fall triggers");
        w1c(8'h20);
        pin_oe[5] = 0;
        tick(3);
        expect_out(8'h00, 1'b0, 3'd0, "R11 release to input");

        // R2 upper word field position, then rewrite lower word
        wr_mask(8'hFF);
        pin_in[4] = 0;
        tick(3);
        expect_out(8'h00, 1'b0, 3'd0, "R2 line 4 rise-mode ignores fall");
        pin_in[4] = 1;
        tick(3);
        expect_out(8'h10, 1'b1, 3'd4, "R2 line 4 rise captured");
        w1c(8'h10);
        wr_sense(1'b0, 8'b00_01_11_11);
        pin_in[0] = 1;
        tick(3);
        expect_out(8'h01, 1'b1, 3'd0, "R2 line 0 retyped to rise");
        w1c(8'h01);
        pin_in[7] = 0;
        tick(2);
        expect_out(8'h00, 1'b1, 3'd7, "R2 line 7 low-level from upper word");
        pin_in[7] = 1;
        tick(2);
        expect_out(8'h00, 1'b0, 3'd0, "R6 line 7 released");

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule